// File: doc/BRIEF.md
# Two-Dimensional DMA Word Address Generator

This block produces the sequence of 32-bit word addresses for a single DMA channel. It has no data path, no bus master and no memory. A companion control block decodes the registers and presents a byte start address, a line length, a line stride, a line count and a direction bit. A one-cycle start strobe launches the walk. Each address leaves on a valid/ready handshake, and the direction bit travels with it unchanged.

A non-zero line length selects grid mode. The block walks a rectangle of lines, one line after another, and raises a single done pulse after the final beat. A zero line length selects ring mode. The block then walks a circular region of `stride * (lines_m1 + 1)` words without end. It raises an event pulse each time the walk completes a half of the region, and keeps going until a stop input ends it at a beat boundary.

Top module: `dma2d_addr_gen`

## Requirements
- R1: A start strobe seen while idle loads all parameters, and the first address issued is the byte start address shifted right by two. Word addresses wrap modulo 2^ADDR_W.
- R2: In grid mode (line length non-zero), each line issues line-length consecutive word addresses.
- R3: In grid mode, each line begins `stride` words after the start of the line before it.
- R4: The line count field holds lines minus one, so 0 gives exactly one line.
- R5: In grid mode, `done` is high for exactly one cycle, in the cycle after the final beat is accepted. In that same cycle `out_valid` is already low.
- R6: In ring mode (line length 0), the address advances one word per accepted beat. After the last word of the `stride*(lines_m1+1)`-word region, it returns to the region start.
- R7: In ring mode, `half_evt` is high for one cycle after the beat that brings the offset to floor(size/2), and after the beat that completes the region. This gives two events per lap. `done` never rises in ring mode.
- R8: `out_dir` carries the loaded direction bit (1 = memory to device, 0 = device to memory) with every address.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_addr` and `out_dir` hold steady.
- R10: In ring mode, `loop_stop` seen high (now or earlier in the run) makes the next accepted beat the last one. After it the block is idle. In grid mode `loop_stop` has no effect.
- R11: A start strobe while a walk is in progress is ignored, and the running walk continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start | input | 1 | Start strobe, one cycle |
| cfg_byte_addr | input | ADDR_W+2 | Byte start address |
| cfg_line_len | input | LEN_W | Words per line; 0 selects ring mode |
| cfg_stride | input | LEN_W | Line pitch in words |
| cfg_lines_m1 | input | CNT_W | Number of lines minus one |
| cfg_dir | input | 1 | Direction: 1 memory to device, 0 device to memory |
| loop_stop | input | 1 | Ends a ring walk at the next beat boundary |
| out_valid | output | 1 | Address available |
| out_ready | input | 1 | Downstream accepts the address |
| out_addr | output | ADDR_W | Word address |
| out_dir | output | 1 | Direction of the current walk |
| done | output | 1 | Grid walk finished, one cycle |
| half_evt | output | 1 | Ring half-region boundary passed, one cycle |

## Verification
Two events can land in the same cycle: a ring-mode stop and a half-region boundary. The bench raises `loop_stop` in the very cycle whose accepted beat closes a half. It checks that the event still fires after that beat and that the walk then goes idle with no done pulse. It also raises the stop while `out_ready` is low and checks that the held beat is still delivered as the last one. The start strobe is also pulsed in the middle of a grid walk that has backpressure, and that walk must go on untouched.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
   typedef enum logic [1:0] {
      WALK_IDLE = 2'd0,
      WALK_GRID = 2'd1,
      WALK_RING = 2'd2
   } walk_mode_e;
endpackage

// File: rtl/dma2d_grid_walk.sv
// Rectangle walker: column and row counters with a running line base.
module dma2d_grid_walk #(
   parameter int ADDR_W = 30,
   parameter int LEN_W  = 16,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] start_word,
   input  logic [LEN_W-1:0]  line_len,
   input  logic [LEN_W-1:0]  stride,
   input  logic [CNT_W-1:0]  lines_m1,
   input  logic              step,
   output logic [ADDR_W-1:0] addr,
   output logic              last_beat
);
   logic [ADDR_W-1:0] line_base_q;
   logic [LEN_W-1:0]  col_q, len_q, stride_q;
   logic [CNT_W-1:0]  row_q, rows_q;
   logic              line_end;

   assign line_end  = (col_q == len_q - LEN_W'(1));
   assign last_beat = line_end && (row_q == rows_q);
   assign addr      = line_base_q + ADDR_W'(col_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_base_q <= '0;
         col_q       <= '0;
         row_q       <= '0;
         len_q       <= '0;
         stride_q    <= '0;
         rows_q      <= '0;
      end else if (load) begin
         line_base_q <= start_word;
         col_q       <= '0;
         row_q       <= '0;
         len_q       <= line_len;
         stride_q    <= stride;
         rows_q      <= lines_m1;
      end else if (step) begin
         if (line_end) begin
            col_q       <= '0;
            row_q       <= row_q + CNT_W'(1);
            line_base_q <= line_base_q + ADDR_W'(stride_q);
         end else begin
            col_q <= col_q + LEN_W'(1);
         end
      end
   end
endmodule

// File: rtl/dma2d_ring_walk.sv
// Circular walker: one offset counter over a region with two halves.
module dma2d_ring_walk #(
   parameter int ADDR_W = 30,
   parameter int LEN_W  = 16,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] start_word,
   input  logic [LEN_W-1:0]  stride,
   input  logic [CNT_W-1:0]  lines_m1,
   input  logic              step,
   output logic [ADDR_W-1:0] addr,
   output logic              boundary
);
   localparam int SZ_W = LEN_W + CNT_W + 1;

   logic [ADDR_W-1:0] base_q;
   logic [SZ_W-1:0]   off_q, size_q, half_q, off_nxt, size_calc;

   assign size_calc = SZ_W'(stride) * (SZ_W'(lines_m1) + SZ_W'(1));
   assign off_nxt   = off_q + SZ_W'(1);
   assign boundary  = (off_nxt == half_q) || (off_nxt == size_q);
   assign addr      = base_q + ADDR_W'(off_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         off_q  <= '0;
         size_q <= '0;
         half_q <= '0;
      end else if (load) begin
         base_q <= start_word;
         off_q  <= '0;
         size_q <= size_calc;
         half_q <= size_calc >> 1;
      end else if (step) begin
         off_q <= (off_nxt == size_q) ? '0 : off_nxt;
      end
   end
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
   import dma2d_pkg::*;
#(
   parameter int ADDR_W = 30,
   parameter int LEN_W  = 16,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_start,
   input  logic [ADDR_W+1:0] cfg_byte_addr,
   input  logic [LEN_W-1:0]  cfg_line_len,
   input  logic [LEN_W-1:0]  cfg_stride,
   input  logic [CNT_W-1:0]  cfg_lines_m1,
   input  logic              cfg_dir,
   input  logic              loop_stop,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [ADDR_W-1:0] out_addr,
   output logic              out_dir,
   output logic              done,
   output logic              half_evt
);
   generate
      if (ADDR_W < 4 || ADDR_W > 62) begin : g_bad_addr
         $error("dma2d_addr_gen: ADDR_W out of range");
      end
      if (LEN_W < 1 || CNT_W < 1) begin : g_bad_len
         $error("dma2d_addr_gen: LEN_W and CNT_W must be positive");
      end
   endgenerate

   walk_mode_e        mode_q;
   logic              stop_pend_q, dir_q, done_q, half_q;
   logic              launch, accept, grid_step, ring_step;
   logic              grid_last, ring_bound, ring_exit;
   logic [ADDR_W-1:0] start_word, grid_addr, ring_addr;

   assign start_word = cfg_byte_addr[ADDR_W+1:2];
   assign launch     = cfg_start && (mode_q == WALK_IDLE);
   assign accept     = (mode_q != WALK_IDLE) && out_ready;
   assign grid_step  = accept && (mode_q == WALK_GRID);
   assign ring_step  = accept && (mode_q == WALK_RING);
   assign ring_exit  = ring_step && (loop_stop || stop_pend_q);

   dma2d_grid_walk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_grid (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (launch),
      .start_word (start_word),
      .line_len   (cfg_line_len),
      .stride     (cfg_stride),
      .lines_m1   (cfg_lines_m1),
      .step       (grid_step),
      .addr       (grid_addr),
      .last_beat  (grid_last)
   );

   dma2d_ring_walk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_ring (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (launch),
      .start_word (start_word),
      .stride     (cfg_stride),
      .lines_m1   (cfg_lines_m1),
      .step       (ring_step),
      .addr       (ring_addr),
      .boundary   (ring_bound)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q      <= WALK_IDLE;
         stop_pend_q <= 1'b0;
         dir_q       <= 1'b0;
         done_q      <= 1'b0;
         half_q      <= 1'b0;
      end else begin
         done_q <= grid_step && grid_last;
         half_q <= ring_step && ring_bound;
         if (launch) begin
            mode_q      <= (cfg_line_len == '0) ? WALK_RING : WALK_GRID;
            dir_q       <= cfg_dir;
            stop_pend_q <= 1'b0;
         end else if ((grid_step && grid_last) || ring_exit) begin
            mode_q      <= WALK_IDLE;
            stop_pend_q <= 1'b0;
         end else if (mode_q == WALK_RING && loop_stop) begin
            stop_pend_q <= 1'b1;
         end
      end
   end

   assign out_valid = (mode_q != WALK_IDLE);
   assign out_addr  = (mode_q == WALK_RING) ? ring_addr : grid_addr;
   assign out_dir   = dir_q;
   assign done      = done_q;
   assign half_evt  = half_q;
endmodule

// File: rtl/dma2d_addr_gen_chk.sv
module dma2d_addr_gen_chk #(
   parameter int ADDR_W = 30
) (
   input logic              clk,
   input logic              rst_n,
   input logic              out_valid,
   input logic              out_ready,
   input logic [ADDR_W-1:0] out_addr,
   input logic              out_dir,
   input logic              done,
   input logic              half_evt,
   input logic              ring_mode
);
   // R9: a stalled beat stays put
   a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_dir));

   // R5: done follows an accepted beat
   a_r5_done_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(out_valid && out_ready));

   // R5: the walk is already idle when done shows
   a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !out_valid);

   // R7: half events only follow ring beats
   a_r7_half_after_ring_beat: assert property (@(posedge clk) disable iff (!rst_n)
      half_evt |-> $past(out_valid && out_ready && ring_mode));

   // R7: ring mode never produces done
   a_r7_no_done_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
      ring_mode && out_valid |=> !done);

   // R7: done and half events never coincide
   a_r7_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && half_evt));
endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_addr  (out_addr),
   .out_dir   (out_dir),
   .done      (done),
   .half_evt  (half_evt),
   .ring_mode (mode_q == dma2d_pkg::WALK_RING)
);

// File: tb/dma2d_addr_gen_bench.sv
`timescale 1ns/1ps
module dma2d_addr_gen_bench;
   localparam int ADDR_W = 30;
   localparam int LEN_W  = 16;
   localparam int CNT_W  = 16;
   localparam longint AMASK = (64'd1 << ADDR_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_start = 1'b0;
   logic [ADDR_W+1:0] cfg_byte_addr = '0;
   logic [LEN_W-1:0]  cfg_line_len = '0;
   logic [LEN_W-1:0]  cfg_stride = '0;
   logic [CNT_W-1:0]  cfg_lines_m1 = '0;
   logic cfg_dir = 1'b0;
   logic loop_stop = 1'b0;
   logic out_ready = 1'b0;
   logic out_valid, out_dir, done, half_evt;
   logic [ADDR_W-1:0] out_addr;

   always #2 clk = ~clk;

   dma2d_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_dma2d_addr_gen (
      .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_byte_addr(cfg_byte_addr),
      .cfg_line_len(cfg_line_len), .cfg_stride(cfg_stride), .cfg_lines_m1(cfg_lines_m1),
      .cfg_dir(cfg_dir), .loop_stop(loop_stop), .out_valid(out_valid), .out_ready(out_ready),
      .out_addr(out_addr), .out_dir(out_dir), .done(done), .half_evt(half_evt)
   );

   int    checks = 0;
   int    fails = 0;
   int    cycles = 0;
   string cur_req = "R1";

   // behavioural reference state
   bit     m_active, m_loop, m_sp, m_dir, m_done, m_half;
   longint m_base, m_lb, m_col, m_row, m_x, m_s, m_y, m_off, m_size;
   int     done_seen, half_seen;

   function automatic longint exp_addr();
      if (m_loop) return (m_base + m_off) & AMASK;
      return (m_lb + m_col) & AMASK;
   endfunction

   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         m_active = 0; m_loop = 0; m_sp = 0; m_dir = 0; m_done = 0; m_half = 0;
      end else begin
         m_done = 0; m_half = 0;
         if (m_active) begin
            if (out_ready) begin
               if (!m_loop) begin
                  if (m_col == m_x - 1) begin
                     m_col = 0;
                     if (m_row == m_y) begin m_active = 0; m_done = 1; end
                     else begin m_row++; m_lb = m_lb + m_s; end
                  end else m_col++;
               end else begin
                  m_off++;
                  if (m_off == m_size / 2 || m_off == m_size) m_half = 1;
                  if (m_off == m_size) m_off = 0;
                  if (loop_stop || m_sp) begin m_active = 0; m_sp = 0; end
               end
            end else if (m_loop && loop_stop) m_sp = 1;
         end else if (cfg_start) begin
            m_active = 1; m_sp = 0;
            m_base = longint'(cfg_byte_addr) >> 2; m_lb = m_base;
            m_x = cfg_line_len; m_s = cfg_stride; m_y = cfg_lines_m1;
            m_loop = (cfg_line_len == 0); m_dir = cfg_dir;
            m_col = 0; m_row = 0; m_off = 0; m_size = m_s * (m_y + 1);
         end
      end
   end

   task automatic check(string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s [%s] actual=%0h expected=%0h at cycle %0d", cur_req, what, act, exp, cycles);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         check("valid", out_valid, m_active);
         if (m_active) begin
            check("addr", out_addr, exp_addr());
            check("dir", out_dir, m_dir);
         end
         check("done", done, m_done);
         check("half", half_evt, m_half);
         if (done) done_seen++;
         if (half_evt) half_seen++;
      end
   end

   task automatic launch(longint baddr, int x, int s, int y, bit d);
      @(negedge clk);
      cfg_byte_addr = (ADDR_W+2)'(baddr);
      cfg_line_len = LEN_W'(x); cfg_stride = LEN_W'(s); cfg_lines_m1 = CNT_W'(y);
      cfg_dir = d; cfg_start = 1'b1;
      @(negedge clk);
      cfg_start = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 2000 && m_active; i++) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cur_req = "R1 reset";
      check("valid", out_valid, 0); check("done", done, 0); check("half", half_evt, 0);

      // R2 R3 R5 R8: 3 lines of 3 words, pitch 5, memory to device
      cur_req = "R2,R3,R5,R8";
      out_ready = 1'b1; done_seen = 0;
      launch(64'h100, 3, 5, 2, 1'b1);
      wait_idle();
      check("done count", done_seen, 1);

      // R4: single line
      cur_req = "R4"; done_seen = 0;
      launch(64'h40, 4, 9, 0, 1'b0);
      wait_idle();
      check("done count", done_seen, 1);

      // R9 R11: backpressure, start pulses during a walk
      cur_req = "R9,R11";
      launch(64'h2000, 4, 16, 3, 1'b1);
      for (int i = 0; i < 12; i++) begin
         out_ready = (i % 3 != 0);
         cfg_start = (i == 4); cfg_byte_addr = 'h8888; cfg_line_len = 1;
         @(negedge clk);
      end
      cfg_start = 1'b0; out_ready = 1'b1;
      wait_idle();

      // R10: stop in grid mode is ignored
      cur_req = "R10 grid"; done_seen = 0;
      launch(64'h300, 2, 2, 2, 1'b0);
      loop_stop = 1'b1;
      wait_idle();
      loop_stop = 1'b0;
      check("done count", done_seen, 1);

      // R6 R7 R10: ring of 8 words (stride 2, 4 lines), stop on a half boundary
      cur_req = "R6,R7"; half_seen = 0; done_seen = 0;
      launch(64'h1000, 0, 2, 3, 1'b1);
      repeat (19) @(negedge clk);   // 20 beats after launch cycle accounting
      cur_req = "R10 ring stop at half";
      n = 0;
      while (m_off != 3 && n < 50) begin @(negedge clk); n++; end
      loop_stop = 1'b1;            // next beat reaches offset 4 = half
      @(negedge clk);
      loop_stop = 1'b0;
      @(negedge clk);
      check("idle after stop", out_valid, 0);
      check("half seen", (half_seen > 0), 1);
      check("no done", done_seen, 0);

      // R6 R7 R10: odd ring of 5 words, stop while stalled
      cur_req = "R6,R7 odd ring"; half_seen = 0;
      launch(64'h4000, 0, 1, 4, 1'b0);
      repeat (10) @(negedge clk);
      check("two halves per lap", (half_seen >= 3), 1);
      cur_req = "R10 stalled stop";
      out_ready = 1'b0; loop_stop = 1'b1;
      @(negedge clk);
      loop_stop = 1'b0;
      repeat (3) @(negedge clk);
      check("held while stalled", out_valid, 1);
      out_ready = 1'b1;
      @(negedge clk);
      check("idle after held beat", out_valid, 0);

      // R1: address wrap at top of word space
      cur_req = "R1 wrap";
      launch(64'hFFFF_FFF8, 4, 4, 1, 1'b1);
      wait_idle();

      repeat (3) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #200000;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule